// File: doc/BRIEF.md
# Vector XOR-Immediate Execution Unit

This unit takes one vector register's worth of data and XORs every element in the active range with a small signed immediate. The immediate is widened by sign extension to a runtime-selected element width. The element width can be 8, 16, 32 or 64 bits, and the register is a parameterised width (default 128 bits). Three things decide whether an element is written: the start index, the vector length and an optional per-element mask. Elements that are not written either keep the previous destination contents or are filled with ones. Two independent policy bits make that choice: one for the tail and one for masked-off elements.

The surrounding pipeline presents the source register, the old destination contents, the mask bits and the control fields, and pulses `start`. Exactly one clock later the new destination value appears on `vd_new` and `valid` pulses for one cycle. `vd_new` holds its value until the next `start`.

Top module: `vxi_unit`

## Requirements
- R1: The `sew` code selects the element width: 00 is 8 bits, 01 is 16, 10 is 32 and 11 is 64. Element i occupies bits [i*EW +: EW], and a register holds VLEN/EW elements.
- R2: A written element equals the source element XOR the 5-bit immediate sign-extended to EW bits. The result keeps the element width and never widens.
- R3: An immediate of 5'b11111 (-1) inverts every bit of each written element, at every element width.
- R4: An element whose index is below `vstart` always keeps its old destination value. This rule takes priority over the tail and mask rules.
- R5: With `vm_n` = 1 (unmasked), every element with `vstart` <= i < `vl` is written.
- R6: With `vm_n` = 0, an element with `vstart` <= i < `vl` is written only when mask bit `v0[i]` is 1. Otherwise it keeps its old value if `ma` = 0, or becomes all ones if `ma` = 1.
- R7: An element with i >= `vl` and i >= `vstart` is a tail element. It keeps its old value if `ta` = 0, or becomes all ones if `ta` = 1, whatever its mask bit.
- R8: `valid` is 1 in exactly the cycle after a cycle with `start` = 1, and 0 otherwise. `vd_new` changes only on a `start` cycle.
- R9: A synchronous active-high `rst` clears `valid` and `vd_new` to zero and overrides `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Operation strobe |
| sew | input | 2 | Element width code |
| vl | input | VLW (5) | Vector length in elements |
| vstart | input | VLW (5) | First element index to process |
| vm_n | input | 1 | 1 = unmasked, 0 = use v0 mask |
| imm | input | 5 | Signed immediate |
| ta | input | 1 | Tail policy: 0 keep, 1 fill ones |
| ma | input | 1 | Mask-off policy: 0 keep, 1 fill ones |
| vs2 | input | VLEN | Source vector register |
| vd_old | input | VLEN | Previous destination contents |
| v0 | input | VLEN/8 | Per-element mask bits |
| vd_new | output | VLEN | Registered result |
| valid | output | 1 | Result strobe, one cycle after start |

## Verification
The hardest situation to reach is where all four element outcomes occur in one register at once: prefix kept, mask-off policy applied, written, and tail policy applied. The rules overlap near the boundaries, including vstart at or beyond vl. The stimulus sweeps every vl from 0 to 16 and several vstart values from 0 to 16, including vstart above vl. It does this at all four element widths, for all eight combinations of mask enable and the two policies, and for eight immediates that include -1 and both sign boundaries. Random source, old and mask data are applied on each vector.

// File: rtl/vxi_pkg.sv
`timescale 1ns/1ps
package vxi_pkg;

    // Element width codes
    typedef enum logic [1:0] {
        SEW8  = 2'b00,
        SEW16 = 2'b01,
        SEW32 = 2'b10,
        SEW64 = 2'b11
    } sew_e;

    localparam int SEW_CNT = 4;

    // Per-element outcome
    typedef enum logic [1:0] {
        ACT_KEEP  = 2'b00,
        ACT_FILL  = 2'b01,
        ACT_WRITE = 2'b10
    } elem_act_e;

    // Policy and masking controls
    typedef struct packed {
        logic vm_n;
        logic ta;
        logic ma;
    } pol_t;

    function automatic logic [63:0] sext5(input logic [4:0] v);
        return {{59{v[4]}}, v};
    endfunction

endpackage

// File: rtl/vxi_elem_ctrl.sv
`timescale 1ns/1ps
module vxi_elem_ctrl
    import vxi_pkg::*;
#(
    parameter int VLW = 5,
    parameter int IDX = 0
) (
    input  logic [VLW-1:0] vl,
    input  logic [VLW-1:0] vstart,
    input  pol_t           pol,
    input  logic           mbit,
    output elem_act_e      act
);
    localparam logic [VLW-1:0] IDX_V = VLW'(IDX);

    // Prefix beats tail, tail beats mask.
    always_comb begin
        if (IDX_V < vstart)
            act = ACT_KEEP;
        else if (IDX_V >= vl)
            act = pol.ta ? ACT_FILL : ACT_KEEP;
        else if (!pol.vm_n && !mbit)
            act = pol.ma ? ACT_FILL : ACT_KEEP;
        else
            act = ACT_WRITE;
    end
endmodule

// File: rtl/vxi_elem_dp.sv
`timescale 1ns/1ps
module vxi_elem_dp
    import vxi_pkg::*;
#(
    parameter int EW = 8
) (
    input  logic [EW-1:0] src,
    input  logic [EW-1:0] old,
    input  logic [4:0]    imm,
    input  elem_act_e     act,
    output logic [EW-1:0] res
);
    logic [63:0]   wide;
    logic [EW-1:0] ext;

    assign wide = sext5(imm);
    assign ext  = wide[EW-1:0];

    always_comb begin
        unique case (act)
            ACT_WRITE: res = src ^ ext;
            ACT_FILL:  res = '1;
            default:   res = old;
        endcase
    end
endmodule

// File: rtl/vxi_sew_lane.sv
`timescale 1ns/1ps
module vxi_sew_lane
    import vxi_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int EW   = 8,
    parameter int VLW  = 5,
    localparam int NE  = VLEN / EW
) (
    input  logic [VLW-1:0]  vl,
    input  logic [VLW-1:0]  vstart,
    input  pol_t            pol,
    input  logic [4:0]      imm,
    input  logic [VLEN-1:0] vs2,
    input  logic [VLEN-1:0] vd_old,
    input  logic [NE-1:0]   v0,
    output logic [VLEN-1:0] res
);
    for (genvar i = 0; i < NE; i++) begin : g_el
        elem_act_e act;

        vxi_elem_ctrl #(.VLW(VLW), .IDX(i)) u_ctrl (
            .vl     (vl),
            .vstart (vstart),
            .pol    (pol),
            .mbit   (v0[i]),
            .act    (act)
        );

        vxi_elem_dp #(.EW(EW)) u_dp (
            .src (vs2[i*EW +: EW]),
            .old (vd_old[i*EW +: EW]),
            .imm (imm),
            .act (act),
            .res (res[i*EW +: EW])
        );
    end
endmodule

// File: rtl/vxi_unit.sv
`timescale 1ns/1ps
module vxi_unit
    import vxi_pkg::*;
#(
    parameter int VLEN  = 128,
    localparam int MASKW = VLEN / 8,
    localparam int VLW   = $clog2(MASKW + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       sew,
    input  logic [VLW-1:0]   vl,
    input  logic [VLW-1:0]   vstart,
    input  logic             vm_n,
    input  logic [4:0]       imm,
    input  logic             ta,
    input  logic             ma,
    input  logic [VLEN-1:0]  vs2,
    input  logic [VLEN-1:0]  vd_old,
    input  logic [MASKW-1:0] v0,
    output logic [VLEN-1:0]  vd_new,
    output logic             valid
);
    pol_t            pol;
    logic [VLEN-1:0] lane_res [SEW_CNT];
    logic [VLEN-1:0] sel;

    assign pol = '{vm_n: vm_n, ta: ta, ma: ma};

    // One lane per element width (R1)
    for (genvar g = 0; g < SEW_CNT; g++) begin : g_lane
        localparam int LEW = 8 << g;
        localparam int LNE = VLEN / LEW;

        vxi_sew_lane #(.VLEN(VLEN), .EW(LEW), .VLW(VLW)) u_lane (
            .vl     (vl),
            .vstart (vstart),
            .pol    (pol),
            .imm    (imm),
            .vs2    (vs2),
            .vd_old (vd_old),
            .v0     (v0[LNE-1:0]),
            .res    (lane_res[g])
        );
    end

    always_comb begin
        unique case (sew_e'(sew))
            SEW8:    sel = lane_res[0];
            SEW16:   sel = lane_res[1];
            SEW32:   sel = lane_res[2];
            default: sel = lane_res[3];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            vd_new <= '0;
        end else begin
            valid <= start;
            if (start)
                vd_new <= sel;
        end
    end

    p_valid_after_start_r8: assert property (@(posedge clk) disable iff (rst)
        start |=> valid);

    p_valid_only_after_start_r8: assert property (@(posedge clk) disable iff (rst)
        !start |=> !valid);

    p_prefix_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(vstart) != '0) |-> vd_new[7:0] == $past(vd_old[7:0]));

    p_tail_undisturbed_r7: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(vl) == '0 && $past(vstart) == '0 && !$past(ta))
        |-> vd_new == $past(vd_old));

    p_tail_agnostic_r7: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(vl) == '0 && $past(vstart) == '0 && $past(ta))
        |-> vd_new == '1);

    p_invert_r3: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(imm) == 5'h1f && $past(vm_n) && $past(vstart) == '0
         && $past(vl) == VLW'(MASKW) && $past(sew) == 2'b00)
        |-> vd_new == ~$past(vs2));
endmodule

// File: tb/sim_vxi_unit.sv
`timescale 1ns/1ps
module sim_vxi_unit;
    localparam int VLEN  = 128;
    localparam int MASKW = VLEN / 8;
    localparam int VLW   = $clog2(MASKW + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic             start;
    logic [1:0]       sew;
    logic [VLW-1:0]   vl;
    logic [VLW-1:0]   vstart;
    logic             vm_n;
    logic [4:0]       imm;
    logic             ta;
    logic             ma;
    logic [VLEN-1:0]  vs2;
    logic [VLEN-1:0]  vd_old;
    logic [MASKW-1:0] v0;
    logic [VLEN-1:0]  vd_new;
    logic             valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    vxi_unit #(.VLEN(VLEN)) u0 (
        .clk(clk), .rst(rst), .start(start), .sew(sew), .vl(vl),
        .vstart(vstart), .vm_n(vm_n), .imm(imm), .ta(ta), .ma(ma),
        .vs2(vs2), .vd_old(vd_old), .v0(v0), .vd_new(vd_new), .valid(valid)
    );

    function automatic logic [VLEN-1:0] rnd_vec();
        logic [VLEN-1:0] r;
        for (int k = 0; k < VLEN / 32; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Compare the result against an element-by-element model built from the requirements
    task automatic check_result(input logic [VLEN-1:0] s, input logic [VLEN-1:0] o,
                                input logic [MASKW-1:0] m);
        int    ew;
        int    ne;
        logic  [63:0] emask;
        logic  [63:0] ext;
        logic  [63:0] se;
        logic  [63:0] oe;
        logic  [63:0] got;
        logic  [63:0] exp;
        string tag;
        bit    bad;
        ew    = 8 << sew;
        ne    = VLEN / ew;
        emask = (ew == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ew) - 64'd1);
        ext   = {{59{imm[4]}}, imm} & emask;
        bad   = 0;
        n_chk++;
        for (int i = 0; i < ne; i++) begin
            se  = 64'(s >> (i * ew)) & emask;
            oe  = 64'(o >> (i * ew)) & emask;
            got = 64'(vd_new >> (i * ew)) & emask;
            if (i < int'(vstart)) begin
                exp = oe; tag = "R4";
            end else if (i >= int'(vl)) begin
                exp = ta ? emask : oe; tag = "R7";
            end else if (!vm_n && !m[i]) begin
                exp = ma ? emask : oe; tag = "R6";
            end else begin
                exp = se ^ ext;
                tag = (imm == 5'h1f) ? "R3" : (vm_n ? "R1,R2,R5" : "R1,R2,R6");
            end
            if (got !== exp && !bad) begin
                bad = 1;
                $display("FAIL %s sew=%0d vl=%0d vstart=%0d elem=%0d got=%h exp=%h",
                         tag, sew, vl, vstart, i, got, exp);
            end
        end
        if (bad) n_fail++;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        int vsts[5] = '{0, 1, 2, 5, 16};
        logic [4:0] imms[8] = '{5'h00, 5'h01, 5'h05, 5'h0f, 5'h10, 5'h1f, 5'h1e, 5'h0a};
        logic [VLEN-1:0]  s_q;
        logic [VLEN-1:0]  o_q;
        logic [MASKW-1:0] m_q;
        logic [VLEN-1:0]  held;

        rst = 1; start = 1; sew = 0; vl = 0; vstart = 0; vm_n = 1; imm = 0;
        ta = 0; ma = 0; vs2 = '1; vd_old = '1; v0 = '1;
        repeat (3) @(negedge clk);
        // R9: reset wins over start and clears the outputs
        n_chk++;
        if (valid !== 1'b0 || vd_new !== '0) begin
            n_fail++;
            $display("FAIL R9 valid=%b vd_new=%h exp valid=0 vd_new=0", valid, vd_new);
        end
        start = 0;
        rst   = 0;
        @(negedge clk);

        for (int sw = 0; sw < 4; sw++)
        for (int l = 0; l <= MASKW; l++)
        for (int vs = 0; vs < 5; vs++)
        for (int p = 0; p < 8; p++)
        for (int k = 0; k < 8; k++) begin
            sew = 2'(sw); vl = VLW'(l); vstart = VLW'(vsts[vs]);
            vm_n = p[0]; ta = p[1]; ma = p[2]; imm = imms[k];
            s_q = rnd_vec(); o_q = rnd_vec(); m_q = MASKW'($urandom);
            vs2 = s_q; vd_old = o_q; v0 = m_q;
            start = 1;
            @(negedge clk);
            start = 0;
            n_chk++;
            if (valid !== 1'b1) begin
                n_fail++;
                $display("FAIL R8 valid after start got=%b exp=1", valid);
            end
            check_result(s_q, o_q, m_q);
            held = vd_new;
            // Disturb the inputs while idle; the output must not move
            vs2 = rnd_vec(); vd_old = rnd_vec(); v0 = MASKW'($urandom); imm = ~imm;
            @(negedge clk);
            n_chk++;
            if (valid !== 1'b0 || vd_new !== held) begin
                n_fail++;
                $display("FAIL R8 idle valid=%b exp=0 vd_new=%h exp=%h", valid, vd_new, held);
            end
        end
        finish_run();
    end
endmodule